// File: doc/BRIEF.md
# Shared Interrupt Sensing and Routing Controller

This block collects a group of external interrupt lines that are shared among several processors. Software configures each line through a small register bus. It chooses how the line is sensed: a high or low level, a rising or falling edge, or both edges. It also controls whether the line is enabled and which processor the line is steered to. Edge events are held in a per-line latch until software acknowledges them. A processor can also set a latch directly through a register write, which provides a simple inter-processor interrupt.

Each processor has one request output. That output is high while any enabled, pending line is steered to that processor. Software reads the pending vector to find which lines need service. Each line also stores a pin-steering field, made of an enable flag and an output pin number, for use by the surrounding interrupt logic. Priority selection and vector generation are left to the logic that consumes the request outputs.

Top module: `irq_route_ctl`

## Requirements
- R1: A read of register group 0 returns in bits [7:0] the value N, where the line count is (N+1)*8. The line count is a multiple of 8 and at most 256, so the default of 16 lines reads back as 1.
- R2: Sense register, group 2, one per line: bit0 selects active-high level or rising edge (1) versus active-low level or falling edge (0); bit1 selects edge (1) or level (0) sensing; bit2 selects dual edge. In level mode, a line is pending exactly while its synchronized input is at the active level.
- R3: Writing a line index (write data bits [7:0]) to group 3 enables that line, and writing it to group 4 disables it. No other line's enable changes. Group 5, indexed by line, returns the enable in bit0.
- R4: In single-edge mode, the selected edge of the synchronized input sets the line's latch. The opposite edge leaves the latch unchanged, and the latch stays set after the input returns to its previous level.
- R5: With bit2 (dual edge) set in edge mode, both rising and falling edges set the latch, whatever the value of bit0.
- R6: Writing to group 6 with bit31 set and a line index in bits [7:0] sets that line's latch. Writing with bit31 clear clears it. If a sensed edge arrives in the same cycle as a clear, the latch is set.
- R7: After reset, every line has sense value 3'b001 (active-high level), every line is disabled, every processor map is zero and every latch is clear.
- R8: Group 7 holds a per-line processor bitmask, with bit c for processor c. Output irqOut[c] is high exactly when some line is pending, enabled and has bit c set. Group 8 holds the pin-steering field: bit31 is the enable flag and bits [PIN_W-1:0] are the pin number, and it reads back as written.
- R9: A read of group 1 with word index w in address bits [7:0] returns pending lines 32w to 32w+31.
- R10: A write whose line index is at or above the line count has no effect on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Register address: [11:8] group, [7:0] line or word index |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqIn | input | NUM_LINES | Raw interrupt lines, asynchronous |
| irqOut | output | NUM_CPUS | Per-processor interrupt request |

## Verification
The bench sweeps every line through all five sense settings. It checks that the latch holds after the input goes back, so a design that passed edges through as levels would show the bit dropping too early. It also checks that an edge of the wrong direction leaves the pending bit clear, and that dual-edge mode ignores the polarity bit. An enable sweep sets one line at a time and reads back every line, which catches index decoding that touches neighbouring lines. Out-of-range indices, latch set and clear through the edge register, and steering of each line to each processor are checked at the request outputs. A wrong processor column would raise the wrong output, and a missing enable gate would raise an output while the line is disabled.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [3:0] {
    GRP_CFG    = 4'd0,
    GRP_PEND   = 4'd1,
    GRP_SENSE  = 4'd2,
    GRP_MSET   = 4'd3,
    GRP_MCLR   = 4'd4,
    GRP_MASK   = 4'd5,
    GRP_EDGE   = 4'd6,
    GRP_CPUMAP = 4'd7,
    GRP_PINMAP = 4'd8
  } regGroup_t;

  typedef struct packed {
    logic dualSel;
    logic edgeSel;
    logic polHigh;
  } senseCfg_t;

  localparam senseCfg_t SENSE_RESET = '{dualSel: 1'b0, edgeSel: 1'b0, polHigh: 1'b1};

  typedef struct packed {
    logic        wrSense;
    logic        wrCpuMap;
    logic        wrPinMap;
    logic        setMask;
    logic        clrMask;
    logic        edgeSet;
    logic        edgeClr;
    logic [7:0]  lineIdx;
    logic [31:0] data;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [11:0] addr,
  input  logic [31:0] wrData,
  output ctrlStrobe_t strb
);

  regGroup_t grp;
  logic      idxFromData;
  logic [7:0] rawIdx;
  logic      idxOk;

  always_comb begin
    grp         = regGroup_t'(addr[11:8]);
    idxFromData = (grp == GRP_MSET) || (grp == GRP_MCLR) || (grp == GRP_EDGE);
    rawIdx      = idxFromData ? wrData[7:0] : addr[7:0];
    idxOk       = ({1'b0, rawIdx} < 9'(NUM_LINES));
  end

  always_comb begin
    strb          = '0;
    strb.lineIdx  = rawIdx;
    strb.data     = wrData;
    if (wrEn && idxOk) begin
      unique case (grp)
        GRP_SENSE:  strb.wrSense  = 1'b1;
        GRP_CPUMAP: strb.wrCpuMap = 1'b1;
        GRP_PINMAP: strb.wrPinMap = 1'b1;
        GRP_MSET:   strb.setMask  = 1'b1;
        GRP_MCLR:   strb.clrMask  = 1'b1;
        GRP_EDGE: begin
          strb.edgeSet = wrData[31];
          strb.edgeClr = !wrData[31];
        end
        default: ;
      endcase
    end
  end

  // R10: at most one action per write
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSense, strb.wrCpuMap, strb.wrPinMap, strb.setMask,
              strb.clrMask, strb.edgeSet, strb.edgeClr}));

  // R10: any strobe implies the write carried an in-range index
  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask || strb.clrMask || strb.edgeSet || strb.edgeClr) |->
      ({1'b0, wrData[7:0]} < 9'(NUM_LINES)));

endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_CPUS  = 2,
  parameter int PIN_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [11:0]          addr,
  output logic [31:0]          rdData,
  output logic [NUM_CPUS-1:0]  irqOut
);

  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int NUM_WORDS = (NUM_LINES + 31) / 32;
  localparam int CFG_N     = NUM_LINES / 8 - 1;

  logic [NUM_LINES-1:0] sync1Q, sync2Q, prevQ;
  logic [NUM_LINES-1:0] maskQ, latchQ, pending;
  senseCfg_t            senseQ  [NUM_LINES];
  logic [NUM_CPUS-1:0]  cpuMapQ [NUM_LINES];
  logic [PIN_W:0]       pinMapQ [NUM_LINES];
  logic [IDX_W-1:0]     curIdx;

  assign curIdx = strb.lineIdx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= irqIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic selHere, riseSeen, fallSeen, edgeHit;

    always_comb begin
      selHere  = (curIdx == IDX_W'(i));
      riseSeen = sync2Q[i] && !prevQ[i];
      fallSeen = !sync2Q[i] && prevQ[i];
      edgeHit  = senseQ[i].edgeSel &&
                 (senseQ[i].dualSel ? (riseSeen || fallSeen)
                                    : (senseQ[i].polHigh ? riseSeen : fallSeen));
      pending[i] = senseQ[i].edgeSel ? latchQ[i]
                                     : (sync2Q[i] == senseQ[i].polHigh);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        senseQ[i]  <= SENSE_RESET;
        maskQ[i]   <= 1'b0;
        latchQ[i]  <= 1'b0;
        cpuMapQ[i] <= '0;
        pinMapQ[i] <= '0;
      end else begin
        if (strb.wrSense && selHere)
          senseQ[i] <= senseCfg_t'(strb.data[2:0]);
        if (strb.wrCpuMap && selHere)
          cpuMapQ[i] <= strb.data[NUM_CPUS-1:0];
        if (strb.wrPinMap && selHere)
          pinMapQ[i] <= {strb.data[31], strb.data[PIN_W-1:0]};
        if (strb.setMask && selHere)
          maskQ[i] <= 1'b1;
        else if (strb.clrMask && selHere)
          maskQ[i] <= 1'b0;
        if (edgeHit || (strb.edgeSet && selHere))
          latchQ[i] <= 1'b1;
        else if (strb.edgeClr && selHere)
          latchQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    irqOut = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        irqOut[c] = irqOut[c] | (pending[i] & maskQ[i] & cpuMapQ[i][c]);
      end
    end
  end

  regGroup_t                grp;
  logic [7:0]               rIdx;
  logic                     rLineOk;
  logic [IDX_W-1:0]         rLine;
  logic [NUM_WORDS*32-1:0]  pendPad;

  always_comb begin
    grp     = regGroup_t'(addr[11:8]);
    rIdx    = addr[7:0];
    rLineOk = ({1'b0, rIdx} < 9'(NUM_LINES));
    rLine   = rIdx[IDX_W-1:0];
    pendPad = '0;
    pendPad[NUM_LINES-1:0] = pending;
    rdData  = '0;
    case (grp)
      GRP_CFG: rdData = 32'(CFG_N);
      GRP_PEND: begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (rIdx == 8'(w)) rdData = pendPad[w*32 +: 32];
        end
      end
      GRP_SENSE:  if (rLineOk) rdData = 32'(senseQ[rLine]);
      GRP_MASK:   if (rLineOk) rdData = 32'(maskQ[rLine]);
      GRP_CPUMAP: if (rLineOk) rdData = 32'(cpuMapQ[rLine]);
      GRP_PINMAP: if (rLineOk) rdData = {pinMapQ[rLine][PIN_W], {(31-PIN_W){1'b0}},
                                         pinMapQ[rLine][PIN_W-1:0]};
      default: rdData = '0;
    endcase
  end

  // R3: an index written to the enable-set register turns that line on
  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask |=> maskQ[$past(curIdx)]);

  // R3: an index written to the enable-clear register turns that line off
  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMask |=> !maskQ[$past(curIdx)]);

  // R6: a software set always leaves the latch pending
  assert_edge_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.edgeSet |=> latchQ[$past(curIdx)]);

  // R7: reset leaves all lines disabled with no latched events
  assert_reset_state_R7: assert property (@(posedge clk)
    !rstN |=> (maskQ == '0 && latchQ == '0));

  // R8: no request leaves the block while every line is disabled
  assert_quiet_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> (irqOut == '0));

endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_CPUS  = 2,
  parameter int PIN_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [11:0]          addr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_CPUS-1:0]  irqOut
);

  ctrlStrobe_t strb;

  irq_route_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .strb   (strb)
  );

  irq_route_datapath #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPUS  (NUM_CPUS),
    .PIN_W     (PIN_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .irqIn  (irqIn),
    .addr   (addr),
    .rdData (rdData),
    .irqOut (irqOut)
  );

  initial begin
    assert_line_count_R1: assert (NUM_LINES % 8 == 0 && NUM_LINES >= 8 && NUM_LINES <= 256);
  end

endmodule

// File: tb/irq_route_ctl_bench.sv
`timescale 1ns/1ps
module irq_route_ctl_bench;

  localparam int NL = 16;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NL-1:0] irqIn = '0;
  logic [NC-1:0] irqOut;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_route_ctl #(.NUM_LINES(NL), .NUM_CPUS(NC), .PIN_W(3)) u_irq_route_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] g, input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    addr = {g, idx}; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] g, input logic [7:0] idx, output logic [31:0] d);
    @(negedge clk);
    addr = {g, idx};
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic setIn(input int l, input logic v);
    @(negedge clk);
    irqIn[l] = v;
  endtask

  // sense, line, expected pend after rise, after fall
  task automatic edgeCase(input int l, input logic [2:0] sense, input logic hr, input logic hf,
                          input string req);
    logic [31:0] d;
    wr(4'd2, 8'(l), {29'd0, sense});
    wr(4'd6, 8'd0, 32'(l));
    setIn(l, 1'b1); settle();
    rd(4'd1, 8'd0, d); check({req, " rise"}, d, hr ? (32'd1 << l) : 32'd0);
    wr(4'd6, 8'd0, 32'(l));
    setIn(l, 1'b0); settle();
    rd(4'd1, 8'd0, d); check({req, " fall"}, d, hf ? (32'd1 << l) : 32'd0);
    wr(4'd6, 8'd0, 32'(l));
    rd(4'd1, 8'd0, d); check({req, " ack"}, d, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R7 reset state, R1 config, R9 pending word
    rd(4'd0, 8'd0, d); check("R1 config", d, 32'd1);
    rd(4'd1, 8'd0, d); check("R9 pend reset", d, 32'd0);
    for (int l = 0; l < NL; l++) begin
      rd(4'd2, 8'(l), d); check("R7 sense reset", d, 32'd1);
      rd(4'd5, 8'(l), d); check("R7 mask reset", d, 32'd0);
      rd(4'd7, 8'(l), d); check("R7 map reset", d, 32'd0);
    end
    check("R7 irqOut reset", 32'(irqOut), 32'd0);

    // R2 level sensing, both polarities, every line
    for (int l = 0; l < NL; l++) begin
      setIn(l, 1'b1); settle();
      rd(4'd1, 8'd0, d); check("R2 level high", d, 32'd1 << l);
      setIn(l, 1'b0); settle();
      rd(4'd1, 8'd0, d); check("R2 level high off", d, 32'd0);
      wr(4'd2, 8'(l), 32'd0); settle();
      rd(4'd1, 8'd0, d); check("R2 level low", d, 32'd1 << l);
      setIn(l, 1'b1); settle();
      rd(4'd1, 8'd0, d); check("R2 level low off", d, 32'd0);
      setIn(l, 1'b0);
      wr(4'd2, 8'(l), 32'd1); settle();
    end

    // R4 single edges, R5 dual edges
    for (int l = 0; l < NL; l++) begin
      edgeCase(l, 3'b011, 1'b1, 1'b0, "R4 rising");
      edgeCase(l, 3'b010, 1'b0, 1'b1, "R4 falling");
      edgeCase(l, 3'b110, 1'b1, 1'b1, "R5 dual pol0");
      edgeCase(l, 3'b111, 1'b1, 1'b1, "R5 dual pol1");
      wr(4'd2, 8'(l), 32'd1);
    end

    // R4 latch holds after input returns
    wr(4'd2, 8'd4, 32'd3);
    setIn(4, 1'b1); settle(); setIn(4, 1'b0); settle();
    rd(4'd1, 8'd0, d); check("R4 latch holds", d, 32'd1 << 4);
    wr(4'd6, 8'd0, 32'd4);
    wr(4'd2, 8'd4, 32'd1);

    // R3 enable sweep
    for (int l = 0; l < NL; l++) begin
      wr(4'd3, 8'd0, 32'(l));
      for (int j = 0; j < NL; j++) begin
        rd(4'd5, 8'(j), d); check("R3 set one", d, (j == l) ? 32'd1 : 32'd0);
      end
      wr(4'd4, 8'd0, 32'(l));
      rd(4'd5, 8'(l), d); check("R3 clear", d, 32'd0);
    end

    // R6 software set/clear gives an IPI, R8 routing
    wr(4'd2, 8'd9, 32'd3);
    wr(4'd7, 8'd9, 32'd1);
    wr(4'd3, 8'd0, 32'd9);
    wr(4'd6, 8'd0, 32'h8000_0009);
    rd(4'd1, 8'd0, d); check("R6 soft set", d, 32'd1 << 9);
    check("R8 ipi to cpu0", 32'(irqOut), 32'd1);
    wr(4'd6, 8'd0, 32'h0000_0009);
    rd(4'd1, 8'd0, d); check("R6 soft clear", d, 32'd0);
    check("R8 ipi cleared", 32'(irqOut), 32'd0);
    wr(4'd4, 8'd0, 32'd9);
    wr(4'd2, 8'd9, 32'd1);
    wr(4'd7, 8'd9, 32'd0);

    // R8 each line to each processor map, gated by enable
    for (int l = 0; l < NL; l++) begin
      setIn(l, 1'b1); settle();
      for (int m = 0; m < 4; m++) begin
        wr(4'd7, 8'(l), 32'(m));
        #1 check("R8 masked quiet", 32'(irqOut), 32'd0);
        wr(4'd3, 8'd0, 32'(l));
        #1 check("R8 route", 32'(irqOut), 32'(m));
        wr(4'd4, 8'd0, 32'(l));
      end
      wr(4'd7, 8'(l), 32'd0);
      setIn(l, 1'b0); settle();
    end
    wr(4'd8, 8'd6, 32'h8000_0005);
    rd(4'd8, 8'd6, d); check("R8 pin map", d, 32'h8000_0005);
    rd(4'd8, 8'd7, d); check("R8 pin map other", d, 32'd0);

    // R10 out of range index ignored
    wr(4'd3, 8'd0, 32'd16);
    wr(4'd6, 8'd0, 32'h8000_0014);
    wr(4'd2, 8'd16, 32'd0);
    for (int j = 0; j < NL; j++) begin
      rd(4'd5, 8'(j), d); check("R10 mask untouched", d, 32'd0);
      rd(4'd2, 8'(j), d); check("R10 sense untouched", d, 32'd1);
    end
    rd(4'd1, 8'd0, d); check("R10 pend untouched", d, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule